// File: doc/BRIEF.md
# Interrupt Acceptance Controller with Stack-Pointer Gating

This block sits between a set of peripheral interrupt sources and a processor core and decides when the core is asked to take an interrupt. There are fifteen maskable sources, arranged as four input-port factors, two programmable-timer factors, three serial factors, four timer factors and two stopwatch factors. There is also one non-maskable watchdog source. Each source pulse sets a pending bit. Software clears a pending bit by writing a one to it. A mask register holds one enable bit per maskable source, and a single global enable flag gates all maskable sources together.

When a pending source is eligible, the block raises a request to the core together with a vector index. The request is held until the core acknowledges it. The acknowledge also clears the global enable flag, so that no further maskable interrupt is taken until software sets the flag again.

Every interrupt, the non-maskable one included, stays locked out until software has written both halves of the stack-pointer pair. A later write to only one half locks interrupts out again until its partner is written. This keeps the core from stacking a return address through a pointer that is only half set up.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A maskable source i (bit i of `src_req`, i from 0 to 14) raises `irq_out` with `irq_vec` = i+1 only when its pending bit is set, `mask_flags` bit i is 1, `ie_flag` is 1 and the gate is open. A masked source, or any source while `ie_flag` is 0, never raises `irq_out`.
- R2: Acceptance is `cpu_ack` high while `irq_out` is high. At that clock edge the block clears `ie_flag` and drops `irq_out`. If a software write of `ie_flag` falls on the same cycle, the acceptance wins and `ie_flag` still ends at 0.
- R3: The watchdog source `nmi_req` raises `irq_out` with `irq_vec` = 0 whatever the values of `ie_flag` and the mask bits.
- R4: From reset, no request is raised until both `sp1_we` and `sp2_we` have been pulsed. The two may come in either order or in the same cycle. Factors that became pending while the block was locked out are presented in the cycle the second write takes effect.
- R5: Once the gate is open, a write to only one stack pointer closes it and withdraws any request that is being held. Repeating the same pointer write does not reopen the gate. Only a write to the partner pointer reopens it.
- R6: A pulse on a source sets its pending bit on the next clock edge, whether or not that source is masked or the gate is open. A one written through `pend_clr_we`/`pend_clr_data` clears that bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: Among eligible maskable sources the lowest-numbered one is presented. A pending watchdog source always takes precedence (vector 0).
- R8: `irq_out` is asserted two clock edges after the source pulse is sampled. While it is asserted, `irq_out` and `irq_vec` stay unchanged until acceptance, even if software clears the pending bit in the meantime. `cpu_ack` while `irq_out` is low has no effect.
- R9: Acceptance of vector 0 clears the watchdog pending state. Acceptance of a maskable vector leaves that source's pending bit set.
- R10: After reset `irq_out`, `ie_flag`, all pending bits and all mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 15 | Request pulses of the maskable sources |
| nmi_req | input | 1 | Request pulse of the watchdog source |
| mask_we | input | 1 | Write strobe of the mask register |
| mask_wdata | input | 15 | New mask value |
| pend_clr_we | input | 1 | Write strobe for clearing pending bits |
| pend_clr_data | input | 15 | Each one clears the matching pending bit |
| ie_we | input | 1 | Write strobe of the global enable flag |
| ie_wdata | input | 1 | New global enable value |
| sp1_we | input | 1 | First stack pointer written |
| sp2_we | input | 1 | Second stack pointer written |
| cpu_ack | input | 1 | Acknowledge pulse from the core |
| irq_out | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Vector index: 0 for watchdog, i+1 for source i |
| ie_flag | output | 1 | Current global enable flag |
| pend_flags | output | 15 | Pending bits of the maskable sources |
| mask_flags | output | 15 | Current mask register |

## Verification
A corrupted gate state shows up in one of two ways. Either a request appears one cycle after a lone pointer write, or a request fails to appear in the cycle the partner write lands, which the bench sees within one clock. A stuck enable flag or a missed acceptance shows up as a second request right after an acknowledge. A lost or stuck watchdog pending state shows up as a missing request, or as a repeated vector 0, within two clocks. A wrong priority or a wrong pending bit appears directly as a wrong `irq_vec` or `pend_flags` value in the cycle the request rises.

// File: rtl/irq_accept_pkg.sv
// Shared types and constants for the interrupt acceptance controller.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_accept_pkg;

    // Stack-pointer pair gate: which half, if any, is still awaited.
    typedef enum logic [1:0] {
        SPG_LOCKED   = 2'd0,   // reset: neither pointer written
        SPG_WAIT_SP2 = 2'd1,   // first pointer written, second awaited
        SPG_WAIT_SP1 = 2'd2,   // second pointer written, first awaited
        SPG_OPEN     = 2'd3    // pair complete, interrupts may be raised
    } spg_state_e;

    // Vector index reserved for the non-maskable watchdog source.
    localparam int unsigned NMI_VECTOR = 0;

endpackage

// File: rtl/irq_sp_gate.sv
// Stack-pointer pair gate. Opens only after both pointer write strobes
// have been seen. A lone write to one pointer closes it again until the
// partner is written. Also gives the next-state open flag so that the
// request logic can withdraw or raise a request on the same edge.
// Assumes: strobes are single-cycle, synchronous to clk.
module irq_sp_gate
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sp1_we,
    input  logic sp2_we,
    output logic gate_open,
    output logic gate_open_nx
);

    spg_state_e state_q, state_d;

    // Next-state decode of the pointer pair.
    always_comb begin
        state_d = state_q;
        if (sp1_we && sp2_we) begin
            state_d = SPG_OPEN;
        end else if (sp1_we) begin
            state_d = (state_q == SPG_WAIT_SP1) ? SPG_OPEN : SPG_WAIT_SP2;
        end else if (sp2_we) begin
            state_d = (state_q == SPG_WAIT_SP2) ? SPG_OPEN : SPG_WAIT_SP1;
        end
    end

    // State register, locked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SPG_LOCKED;
        else        state_q <= state_d;
    end

    assign gate_open    = (state_q == SPG_OPEN);
    assign gate_open_nx = (state_d == SPG_OPEN);

endmodule

// File: rtl/irq_factor_bank.sv
// Per-source pending and mask bits. A request pulse sets a pending bit,
// and a software one-write clears it. A set wins over a simultaneous
// clear. The mask register is written as a whole word.
// Assumes: request pulses are synchronous to clk.
module irq_factor_bank #(
    parameter int unsigned N_SRC = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             pend_clr_we,
    input  logic [N_SRC-1:0] pend_clr_data,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    output logic [N_SRC-1:0] pend,
    output logic [N_SRC-1:0] mask
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic pend_q;
        logic mask_q;

        // Pending bit: set by pulse, cleared by write-one.
        always_ff @(posedge clk) begin
            if (!rst_n)                                pend_q <= 1'b0;
            else if (src_req[g])                       pend_q <= 1'b1;
            else if (pend_clr_we && pend_clr_data[g])  pend_q <= 1'b0;
        end

        // Mask bit: loaded by the mask register write.
        always_ff @(posedge clk) begin
            if (!rst_n)       mask_q <= 1'b0;
            else if (mask_we) mask_q <= mask_wdata[g];
        end

        assign pend[g] = pend_q;
        assign mask[g] = mask_q;
    end

endmodule

// File: rtl/irq_pick.sv
// Fixed-priority selector. The watchdog factor wins outright; otherwise
// the lowest-numbered enabled pending maskable source is chosen, and its
// vector is its index plus one.
// Assumes: VEC_W is wide enough for N_SRC+1 vectors.
module irq_pick
    import irq_accept_pkg::*;
#(
    parameter int unsigned N_SRC = 15,
    parameter int unsigned VEC_W = 4
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] mask,
    input  logic             ie,
    input  logic             nmi_pend,
    output logic             hit,
    output logic [VEC_W-1:0] vec
);

    // Scan from the top so the lowest index is the last to win.
    always_comb begin
        hit = 1'b0;
        vec = VEC_W'(NMI_VECTOR);
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i] && mask[i] && ie) begin
                hit = 1'b1;
                vec = VEC_W'(i + 1);
            end
        end
        if (nmi_pend) begin
            hit = 1'b1;
            vec = VEC_W'(NMI_VECTOR);
        end
    end

endmodule

// File: rtl/irq_accept_ctrl.sv
// Interrupt acceptance controller. Latches the source factors, holds the
// global enable flag, and presents one request with a vector to the core
// until it is acknowledged. The whole block is gated by the stack-pointer
// pair state. Acceptance clears the global enable flag and, for the
// watchdog vector, the watchdog pending state.
// Assumes: all inputs are synchronous single-cycle strobes on clk.
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int unsigned N_SRC = 15,
    localparam int unsigned VEC_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             nmi_req,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             pend_clr_we,
    input  logic [N_SRC-1:0] pend_clr_data,
    input  logic             ie_we,
    input  logic             ie_wdata,
    input  logic             sp1_we,
    input  logic             sp2_we,
    input  logic             cpu_ack,
    output logic             irq_out,
    output logic [VEC_W-1:0] irq_vec,
    output logic             ie_flag,
    output logic [N_SRC-1:0] pend_flags,
    output logic [N_SRC-1:0] mask_flags
);

    logic             gate_open;
    logic             gate_open_nx;
    logic             nmi_pend;
    logic             ie_q;
    logic             req_q;
    logic [VEC_W-1:0] vec_q;
    logic             pick_hit;
    logic [VEC_W-1:0] pick_vec;
    logic             accept;

    irq_sp_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .sp1_we       (sp1_we),
        .sp2_we       (sp2_we),
        .gate_open    (gate_open),
        .gate_open_nx (gate_open_nx)
    );

    irq_factor_bank #(.N_SRC(N_SRC)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_req       (src_req),
        .pend_clr_we   (pend_clr_we),
        .pend_clr_data (pend_clr_data),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .pend          (pend_flags),
        .mask          (mask_flags)
    );

    irq_pick #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pick (
        .pend     (pend_flags),
        .mask     (mask_flags),
        .ie       (ie_q),
        .nmi_pend (nmi_pend),
        .hit      (pick_hit),
        .vec      (pick_vec)
    );

    assign accept = req_q && cpu_ack;

    // Global enable flag: software write, cleared by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= 1'b0;
        else if (accept) ie_q <= 1'b0;
        else if (ie_we) ie_q <= ie_wdata;
    end

    // Watchdog pending state: set by pulse, cleared by its own acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_pend <= 1'b0;
        else if (nmi_req)
            nmi_pend <= 1'b1;
        else if (accept && vec_q == VEC_W'(NMI_VECTOR))
            nmi_pend <= 1'b0;
    end

    // Request holder: raised from the selector, held until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= '0;
        end else if (!gate_open_nx) begin
            req_q <= 1'b0;
        end else if (req_q) begin
            if (cpu_ack) req_q <= 1'b0;
        end else if (pick_hit) begin
            req_q <= 1'b1;
            vec_q <= pick_vec;
        end
    end

    assign irq_out = req_q;
    assign irq_vec = vec_q;
    assign ie_flag = ie_q;

endmodule

// File: rtl/irq_accept_ctrl_chk.sv
// Assertion checker for the interrupt acceptance controller, attached by
// bind. It watches the ports together with the gate and watchdog state.
// Assumes: synchronous active-low reset on rst_n.
module irq_accept_ctrl_chk #(
    parameter int unsigned N_SRC = 15,
    parameter int unsigned VEC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_req,
    input logic             cpu_ack,
    input logic             sp1_we,
    input logic             sp2_we,
    input logic             irq_out,
    input logic [VEC_W-1:0] irq_vec,
    input logic             ie_flag,
    input logic [N_SRC-1:0] pend_flags,
    input logic             gate_open,
    input logic             nmi_pend
);

    // R1: a maskable vector can only rise if the enable flag was set.
    p_masked_needs_ie_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_out) && irq_vec != '0) |-> $past(ie_flag));

    // R2: acceptance clears the enable flag and drops the request.
    p_accept_clears_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && cpu_ack) |=> (!ie_flag && !irq_out));

    // R3: vector 0 rises only from a pending watchdog factor.
    p_nmi_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_out) && irq_vec == '0) |-> $past(nmi_pend));

    // R4: a request can only rise while the gate is open.
    p_rise_needs_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> gate_open);

    // R5: a lone pointer write closes the gate and withdraws the request.
    p_single_write_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && (sp1_we != sp2_we)) |=> (!gate_open && !irq_out));

    // R6: every pulsed source shows as pending one edge later.
    p_pend_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_req) |=> ((pend_flags & $past(src_req)) == $past(src_req)));

    // R8: an unacknowledged request holds with a stable vector.
    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !cpu_ack && !sp1_we && !sp2_we) |=> (irq_out && $stable(irq_vec)));

endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .cpu_ack    (cpu_ack),
    .sp1_we     (sp1_we),
    .sp2_we     (sp2_we),
    .irq_out    (irq_out),
    .irq_vec    (irq_vec),
    .ie_flag    (ie_flag),
    .pend_flags (pend_flags),
    .gate_open  (gate_open),
    .nmi_pend   (nmi_pend)
);

// File: tb/irq_accept_ctrl_test.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, pointer gating and corner cases.
module irq_accept_ctrl_test;

    localparam int N = 15;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0;
    logic          nmi_req = 1'b0;
    logic          mask_we = 1'b0;
    logic [N-1:0]  mask_wdata = '0;
    logic          pend_clr_we = 1'b0;
    logic [N-1:0]  pend_clr_data = '0;
    logic          ie_we = 1'b0;
    logic          ie_wdata = 1'b0;
    logic          sp1_we = 1'b0;
    logic          sp2_we = 1'b0;
    logic          cpu_ack = 1'b0;
    logic          irq_out;
    logic [VW-1:0] irq_vec;
    logic          ie_flag;
    logic [N-1:0]  pend_flags;
    logic [N-1:0]  mask_flags;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_accept_ctrl #(.N_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .nmi_req(nmi_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .pend_clr_we(pend_clr_we), .pend_clr_data(pend_clr_data),
        .ie_we(ie_we), .ie_wdata(ie_wdata), .sp1_we(sp1_we), .sp2_we(sp2_we),
        .cpu_ack(cpu_ack), .irq_out(irq_out), .irq_vec(irq_vec),
        .ie_flag(ie_flag), .pend_flags(pend_flags), .mask_flags(mask_flags)
    );

    // Table fields: {src, nmi, mask, ie, expected irq, expected vector}
    localparam logic [36:0] TAB [8] = '{
        {15'h0001, 1'b0, 15'h0001, 1'b1, 1'b1, 4'd1},   // R1 enabled source 0
        {15'h0001, 1'b0, 15'h0000, 1'b1, 1'b0, 4'd0},   // R1 masked
        {15'h0008, 1'b0, 15'h0008, 1'b0, 1'b0, 4'd0},   // R1 enable flag low
        {15'h0000, 1'b1, 15'h0000, 1'b0, 1'b1, 4'd0},   // R3 watchdog, flag low
        {15'h0220, 1'b0, 15'h7FFF, 1'b1, 1'b1, 4'd6},   // R7 lowest of 5 and 9
        {15'h4000, 1'b0, 15'h4000, 1'b1, 1'b1, 4'd15},  // R7 top source
        {15'h0004, 1'b1, 15'h7FFF, 1'b1, 1'b1, 4'd0},   // R7 watchdog wins
        {15'h0090, 1'b0, 15'h0080, 1'b1, 1'b1, 4'd8}    // R1 masked lower bit
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [N-1:0] v);
        mask_we = 1'b1; mask_wdata = v; tick(); mask_we = 1'b0;
    endtask

    task automatic wr_ie(input logic v);
        ie_we = 1'b1; ie_wdata = v; tick(); ie_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] s, input logic n);
        src_req = s; nmi_req = n; tick(); src_req = '0; nmi_req = 1'b0;
    endtask

    task automatic clr(input logic [N-1:0] v);
        pend_clr_we = 1'b1; pend_clr_data = v; tick(); pend_clr_we = 1'b0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
    endtask

    task automatic sp(input logic a, input logic b);
        sp1_we = a; sp2_we = b; tick(); sp1_we = 1'b0; sp2_we = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        chk(irq_out, 0, "R10 irq after reset");
        chk(ie_flag, 0, "R10 ie after reset");
        chk(pend_flags, 0, "R10 pending after reset");
        chk(mask_flags, 0, "R10 mask after reset");

        // R4 locked before the pointer pair is written
        wr_mask('1);
        wr_ie(1'b1);
        pulse(15'h0001, 1'b1);
        tick(); tick();
        chk(irq_out, 0, "R4 locked after reset");
        chk(pend_flags, 15'h0001, "R6 pending latched while locked");
        sp(1'b1, 1'b0);
        tick();
        chk(irq_out, 0, "R4 locked after first pointer only");
        sp(1'b0, 1'b1);
        chk(irq_out, 1, "R4 open after pair");
        chk(irq_vec, 0, "R7 watchdog first");
        ack();
        chk(irq_out, 0, "R2 request dropped on accept");
        chk(ie_flag, 0, "R2 ie cleared on accept");
        chk(pend_flags[0], 1, "R9 maskable pending kept");
        wr_ie(1'b1);
        tick();
        chk(irq_out, 1, "R1 source 0 after re-enable");
        chk(irq_vec, 1, "R1 vector of source 0");
        ack();
        clr('1);

        // Table walk
        foreach (TAB[k]) begin
            logic [N-1:0] t_src;
            logic t_nmi, t_ie, t_irq;
            logic [N-1:0] t_mask;
            logic [3:0] t_vec;
            {t_src, t_nmi, t_mask, t_ie, t_irq, t_vec} = TAB[k];
            mask_we = 1'b1; mask_wdata = t_mask;
            ie_we = 1'b1; ie_wdata = t_ie;
            tick();
            mask_we = 1'b0; ie_we = 1'b0;
            pulse(t_src, t_nmi);
            tick();
            chk(irq_out, t_irq, $sformatf("R1/R3/R7 table %0d irq", k));
            if (t_irq) begin
                chk(irq_vec, t_vec, $sformatf("R7 table %0d vector", k));
                ack();
                chk(ie_flag, 0, $sformatf("R2 table %0d ie after accept", k));
            end
            clr('1);
            chk(pend_flags, 0, $sformatf("R6 table %0d cleared", k));
        end

        // R5 lone first-pointer write re-locks; repeated write does not reopen
        sp(1'b1, 1'b0);
        pulse('0, 1'b1);
        tick();
        chk(irq_out, 0, "R5 locked after lone sp1");
        sp(1'b1, 1'b0);
        tick();
        chk(irq_out, 0, "R5 repeated sp1 stays locked");
        sp(1'b0, 1'b1);
        chk(irq_out, 1, "R5 partner reopens");
        chk(irq_vec, 0, "R3 watchdog vector");
        ack();
        tick(); tick();
        chk(irq_out, 0, "R9 watchdog pending cleared by accept");

        // R5 lone second-pointer write, reopened by sp1
        sp(1'b0, 1'b1);
        sp(1'b0, 1'b1);
        pulse('0, 1'b1);
        tick();
        chk(irq_out, 0, "R5 locked after lone sp2");
        sp(1'b1, 1'b0);
        chk(irq_out, 1, "R5 sp1 reopens");
        ack();

        // R5 held request withdrawn by lone write
        wr_mask('1);
        wr_ie(1'b1);
        pulse(15'h0010, 1'b0);
        tick();
        chk(irq_vec, 5, "R1 source 4 vector");
        sp(1'b0, 1'b1);
        chk(irq_out, 0, "R5 held request withdrawn");
        sp(1'b1, 1'b0);
        chk(irq_out, 1, "R5 request re-raised");
        repeat (4) tick();
        chk(irq_out, 1, "R8 held without ack");
        chk(irq_vec, 5, "R8 vector stable");
        clr(15'h0010);
        chk(irq_out, 1, "R8 held after pending clear");
        chk(irq_vec, 5, "R8 vector stable after clear");
        // R2 acceptance beats a same-cycle enable write
        cpu_ack = 1'b1; ie_we = 1'b1; ie_wdata = 1'b1;
        tick();
        cpu_ack = 1'b0; ie_we = 1'b0;
        chk(ie_flag, 0, "R2 accept beats ie write");
        chk(irq_out, 0, "R2 request dropped");

        // R8 ack without a request has no effect
        wr_ie(1'b1);
        ack();
        chk(ie_flag, 1, "R8 idle ack leaves ie");
        chk(irq_out, 0, "R8 idle ack no request");

        // R6 set wins over same-cycle clear
        src_req = 15'h0008; pend_clr_we = 1'b1; pend_clr_data = 15'h0008;
        tick();
        src_req = '0; pend_clr_we = 1'b0;
        chk(pend_flags, 15'h0008, "R6 set beats clear");
        tick();
        chk(irq_vec, 4, "R7 source 3 vector");
        ack();
        clr('1);

        summary();
        $finish;
    end

endmodule